// File: doc/BRIEF.md
# SPI Target Port with Buffered Transfer

This block is the responding end of an SPI link. It generates no serial clock. The external controller drives SCLK and, in four-wire mode, a select line. Before a transfer, system logic places one word in a single-entry transmit buffer through a valid/ready stream. The block cannot know when the controller will start clocking, so it holds that word. When the edges arrive, it shifts the word out on MISO.

At the same time, each bit on MOSI is collected into a receive shift register. A completed frame is handed to a one-entry receive holding register, which is offered on a valid/ready output stream. All serial inputs pass through two-flop synchronisers. Edges are detected in the system clock domain.

A set of plain configuration pins selects how the block matches the controller:
- clock idle level (polarity) and phase;
- bit order;
- 7-bit or 8-bit frames;
- three-wire or four-wire operation;
- the active level of the select line.

Transmit stream rules:
- A word is accepted on a cycle where `tx_valid_i` and `tx_ready_o` are both high.
- `tx_ready_o` then stays low until the controller has clocked a whole frame built from that word.
- Low `tx_ready_o` is the only back-pressure on that side.

Receive stream rules:
- A received word is taken on a cycle where `rx_valid_o` and `rx_ready_i` are both high.
- The controller cannot be stalled. If the consumer is slow, a newer frame overwrites the held word.

Top module: `spi_target_port`

## Requirements
- R1: After reset `tx_ready_o` is 1, `rx_valid_o` is 0 and, in four-wire mode with select inactive, `miso_oe_o` is 0.
- R2: `tx_ready_o` falls on the clock after a `tx_valid_i`/`tx_ready_o` handshake. It stays 0 until the controller has completed a full frame that carried the accepted word, and then it returns to 1.
- R3: The leading edge is the SCLK transition away from the idle level given by `cfg_cpol_i`.
  - With `cfg_cpha_i`=0, the first bit is on MISO before the first edge. MOSI is sampled on leading edges and MISO advances on trailing edges.
  - With `cfg_cpha_i`=1, MISO advances on leading edges and MOSI is sampled on trailing edges.
- R4: With `cfg_msb_first_i`=0, bit 0 of the word travels first in both directions. With 1, the highest frame bit travels first.
- R5: With `cfg_short_i`=1 a frame is 7 bits. Only transmit bits 6..0 are sent, and `rx_data_o` bit 7 reads 0. With `cfg_short_i`=0 a frame is 8 bits.
- R6: After the last sample of a frame, `rx_data_o` holds the received word and `rx_valid_o` is 1. These stay unchanged until `rx_ready_i` is seen with `rx_valid_o`, or until a newer frame overwrites the data.
- R7: In four-wire mode, select is active when `sel_i` equals `cfg_sel_high_i`. While select is inactive:
  - SCLK edges are ignored;
  - `miso_oe_o` is 0;
  - an unfinished frame is dropped without touching either buffer, and the next frame starts again from its first bit.
- R8: In three-wire mode (`cfg_four_wire_i`=0) the block is always selected and `miso_oe_o` is 1.
- R9: A frame that starts while the transmit buffer is empty sends the word of the previous frame again, or 0 if no frame has been sent since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_cpol_i | input | 1 | SCLK idle level |
| cfg_cpha_i | input | 1 | Phase: 0 samples on leading edge, 1 on trailing edge |
| cfg_msb_first_i | input | 1 | 1 sends the highest frame bit first |
| cfg_short_i | input | 1 | 1 selects 7-bit frames |
| cfg_four_wire_i | input | 1 | 1 uses the select input |
| cfg_sel_high_i | input | 1 | Active level of select in four-wire mode |
| sclk_i | input | 1 | Serial clock from the controller |
| mosi_i | input | 1 | Serial data from the controller |
| sel_i | input | 1 | Select from the controller |
| miso_o | output | 1 | Serial data to the controller |
| miso_oe_o | output | 1 | Drive enable for MISO |
| tx_valid_i | input | 1 | Transmit word offered |
| tx_ready_o | output | 1 | Transmit buffer empty |
| tx_data_i | input | 8 | Transmit word |
| rx_valid_o | output | 1 | Received word held |
| rx_ready_i | input | 1 | Consumer takes the received word |
| rx_data_o | output | 8 | Received word |

## Verification
The assertions assume the following about the inputs:
- Each SCLK level lasts several system clocks, so every synchronised transition produces exactly one edge pulse.
- Configuration pins change only while the block is deselected, or while SCLK rests at its idle level between frames, so the frame length cannot shrink under a running count.

The stimulus holds each SCLK level for six system clocks. It changes polarity, phase, order and length only with select inactive, with SCLK already moved to the new idle level. It enters three-wire mode only while SCLK rests.

// File: rtl/spit_pkg.sv
package spit_pkg;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic msb_first;
    logic short_frame;
    logic four_wire;
    logic sel_high;
  } spit_cfg_t;

endpackage

// File: rtl/spit_sync.sv
module spit_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[0] <= '0;
        else         st_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[s] <= '0;
        else         st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spit_edges.sv
module spit_edges
  import spit_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  spit_cfg_t cfg_i,
  input  logic      active_i,
  input  logic      sclk_s_i,
  output logic      sample_p_o,
  output logic      shift_p_o
);
  logic sclk_d_q;
  logic rise, fall, lead, trail;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= sclk_s_i;

  assign rise  = sclk_s_i & ~sclk_d_q;
  assign fall  = ~sclk_s_i & sclk_d_q;
  assign lead  = cfg_i.cpol ? fall : rise;
  assign trail = cfg_i.cpol ? rise : fall;

  assign sample_p_o = active_i & (cfg_i.cpha ? trail : lead);
  assign shift_p_o  = active_i & (cfg_i.cpha ? lead : trail);

  // R3: one SCLK level change can never be both a sampling and a shifting edge
  a_r3_edges_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_p_o && shift_p_o));
endmodule

// File: rtl/spit_engine.sv
module spit_engine
  import spit_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  spit_cfg_t         cfg_i,
  input  logic              active_i,
  input  logic              sample_p_i,
  input  logic              shift_p_i,
  input  logic              mosi_s_i,
  input  logic [DATA_W-1:0] src_word_i,
  input  logic              src_new_i,
  output logic              miso_bit_o,
  output logic              frame_done_o,
  output logic              done_new_o,
  output logic [DATA_W-1:0] cur_word_o,
  output logic [DATA_W-1:0] rx_word_o
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam int IW = $clog2(DATA_W);

  logic [CW-1:0]     len, rc_q, tp_q, shown, opos, spos;
  logic [DATA_W-1:0] cur_q, rsr_q;
  logic              used_q, idle, last_sample;

  assign len         = cfg_i.short_frame ? CW'(DATA_W - 1) : CW'(DATA_W);
  assign idle        = (rc_q == '0) && (tp_q == '0);
  assign last_sample = sample_p_i && (rc_q == len - 1'b1);

  assign spos  = cfg_i.msb_first ? (len - 1'b1 - rc_q) : rc_q;
  assign shown = (cfg_i.cpha && tp_q != '0) ? (tp_q - 1'b1) : tp_q;
  assign opos  = cfg_i.msb_first ? (len - 1'b1 - shown) : shown;

  assign miso_bit_o   = cur_q[opos[IW-1:0]];
  assign frame_done_o = last_sample;
  assign done_new_o   = last_sample && used_q;
  assign cur_word_o   = cur_q;

  always_comb begin
    rx_word_o = rsr_q;
    rx_word_o[spos[IW-1:0]] = mosi_s_i;
    if (cfg_i.short_frame) rx_word_o[DATA_W-1] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rc_q   <= '0;
      tp_q   <= '0;
      rsr_q  <= '0;
      cur_q  <= '0;
      used_q <= 1'b0;
    end else begin
      if (idle) begin
        cur_q  <= src_word_i;
        used_q <= src_new_i;
      end
      if (!active_i) begin
        rc_q <= '0;
        tp_q <= '0;
      end else begin
        if (sample_p_i) begin
          rsr_q[spos[IW-1:0]] <= mosi_s_i;
          rc_q <= last_sample ? '0 : rc_q + 1'b1;
          if (last_sample && cfg_i.cpha) tp_q <= '0;
        end
        if (shift_p_i) begin
          if (!cfg_i.cpha && rc_q == '0) tp_q <= '0;
          else                           tp_q <= tp_q + 1'b1;
        end
      end
    end
  end

  // R7: a deselected cycle leaves no partial frame behind
  a_r7_deselect_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (rc_q == '0 && tp_q == '0));
  // R5: the sample count stays inside the configured frame length
  a_r5_count_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rc_q < len);
endmodule

// File: rtl/spit_txq.sv
module spit_txq #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  input  logic              frame_done_i,
  input  logic              done_new_i,
  input  logic [DATA_W-1:0] cur_word_i,
  output logic [DATA_W-1:0] src_word_o,
  output logic              src_new_o
);
  logic [DATA_W-1:0] buf_q, last_q;
  logic              full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      last_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (frame_done_i) last_q <= cur_word_i;
      if (done_new_i) full_q <= 1'b0;
      else if (tx_valid_i && !full_q) begin
        buf_q  <= tx_data_i;
        full_q <= 1'b1;
      end
    end
  end

  assign tx_ready_o = ~full_q;
  assign src_word_o = full_q ? buf_q : last_q;
  assign src_new_o  = full_q;

  // R2: the buffer frees up only after a completed frame
  a_r2_ready_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_ready_o) |-> $past(frame_done_i));
  // R9: the repeat word only changes when a frame completes
  a_r9_last_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(last_q) |-> $past(frame_done_i));
endmodule

// File: rtl/spi_target_port.sv
module spi_target_port
  import spit_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_cpol_i,
  input  logic              cfg_cpha_i,
  input  logic              cfg_msb_first_i,
  input  logic              cfg_short_i,
  input  logic              cfg_four_wire_i,
  input  logic              cfg_sel_high_i,
  input  logic              sclk_i,
  input  logic              mosi_i,
  input  logic              sel_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [DATA_W-1:0] rx_data_o
);
  spit_cfg_t         cfg;
  logic              sclk_s, mosi_s, sel_s, active;
  logic              sample_p, shift_p, miso_bit, frame_done, done_new, src_new;
  logic [DATA_W-1:0] src_word, cur_word, rx_word;

  assign cfg = '{cpol: cfg_cpol_i, cpha: cfg_cpha_i, msb_first: cfg_msb_first_i,
                 short_frame: cfg_short_i, four_wire: cfg_four_wire_i,
                 sel_high: cfg_sel_high_i};

  spit_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({sclk_i, mosi_i, sel_i}),
    .q_o ({sclk_s, mosi_s, sel_s})
  );

  assign active = cfg.four_wire ? (sel_s == cfg.sel_high) : 1'b1;

  spit_edges u_edges (
    .clk_i, .rst_ni, .cfg_i(cfg), .active_i(active), .sclk_s_i(sclk_s),
    .sample_p_o(sample_p), .shift_p_o(shift_p)
  );

  spit_engine #(.DATA_W(DATA_W)) u_engine (
    .clk_i, .rst_ni, .cfg_i(cfg), .active_i(active),
    .sample_p_i(sample_p), .shift_p_i(shift_p), .mosi_s_i(mosi_s),
    .src_word_i(src_word), .src_new_i(src_new),
    .miso_bit_o(miso_bit), .frame_done_o(frame_done), .done_new_o(done_new),
    .cur_word_o(cur_word), .rx_word_o(rx_word)
  );

  spit_txq #(.DATA_W(DATA_W)) u_txq (
    .clk_i, .rst_ni, .tx_valid_i, .tx_data_i, .tx_ready_o,
    .frame_done_i(frame_done), .done_new_i(done_new), .cur_word_i(cur_word),
    .src_word_o(src_word), .src_new_o(src_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
    end else if (frame_done) begin
      rx_valid_o <= 1'b1;
      rx_data_o  <= rx_word;
    end else if (rx_ready_i) begin
      rx_valid_o <= 1'b0;
    end
  end

  assign miso_oe_o = active;
  assign miso_o    = active & miso_bit;

  // R6: a held word is not withdrawn before the consumer takes it
  a_r6_hold_until_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o && !rx_ready_i |=> rx_valid_o);
  // R6: held data changes only when a newer frame lands
  a_r6_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o && !rx_ready_i && !frame_done |=> $stable(rx_data_o));
endmodule

// File: tb/spi_target_port_tb_top.sv
module spi_target_port_tb_top;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpol = 0, cpha = 0, msbf = 0, shrt = 0, four = 1, selh = 0;
  logic sclk = 0, mosi = 0, sel = 1;
  logic miso, miso_oe, tx_valid = 0, tx_ready, rx_valid, rx_ready = 0;
  logic [7:0] tx_data = '0, rx_data;

  int nvec = 0, nerr = 0;
  bit done_flag = 0;

  // behavioural model state
  bit m_full = 0;
  logic [7:0] m_buf = '0, m_last = '0;

  always #4 clk = ~clk;

  spi_target_port dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_cpol_i(cpol), .cfg_cpha_i(cpha), .cfg_msb_first_i(msbf),
    .cfg_short_i(shrt), .cfg_four_wire_i(four), .cfg_sel_high_i(selh),
    .sclk_i(sclk), .mosi_i(mosi), .sel_i(sel),
    .miso_o(miso), .miso_oe_o(miso_oe),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_data_i(tx_data),
    .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .rx_data_o(rx_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int flen();
    return shrt ? 7 : 8;
  endfunction

  function automatic logic [7:0] fmask();
    return shrt ? 8'h7F : 8'hFF;
  endfunction

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    chk("R2 ready before push", tx_ready, 1);
    tx_valid = 1; tx_data = d;
    @(negedge clk);
    tx_valid = 0;
    chk("R2 ready drops after push", tx_ready, 0);
    m_full = 1; m_buf = d;
  endtask

  task automatic pop(input logic [7:0] exp);
    @(negedge clk);
    chk("R6 valid before pop", rx_valid, 1);
    chk("R6 data before pop", rx_data, exp);
    rx_ready = 1;
    @(negedge clk);
    rx_ready = 0;
    chk("R6 valid cleared by pop", rx_valid, 0);
  endtask

  // controller drives nb bits; a full frame also updates the model and checks flags
  task automatic frame(input logic [7:0] mw, input int nb);
    int len = flen();
    logic [7:0] src = m_full ? m_buf : m_last;
    if (four) sel = selh;
    wclk(H);
    for (int i = 0; i < nb; i++) begin
      int pos = msbf ? len - 1 - i : i;
      if (!cpha) begin
        mosi = mw[pos];
        wclk(H);
        chk("R3 R4 R5 miso bit (phase 0)", miso, src[pos]);
        chk("R7 R8 drive enable in frame", miso_oe, 1);
        sclk = ~cpol;
        wclk(H);
        sclk = cpol;
      end else begin
        sclk = ~cpol;
        mosi = mw[pos];
        wclk(H);
        chk("R3 R4 R5 miso bit (phase 1)", miso, src[pos]);
        chk("R7 R8 drive enable in frame", miso_oe, 1);
        sclk = cpol;
        wclk(H);
      end
    end
    wclk(H);
    if (four) sel = ~selh;
    wclk(H);
    if (nb == len) begin
      m_last = src; m_full = 0;
      chk("R2 ready after frame", tx_ready, 1);
      chk("R6 valid after frame", rx_valid, 1);
      chk("R4 R5 R6 received word", rx_data, mw & fmask());
    end
  endtask

  // idle-time reconfiguration: only with select inactive in four-wire mode
  task automatic setcfg(input logic p, input logic ph, input logic m, input logic s,
                        input logic sh);
    @(negedge clk);
    selh = sh; sel = ~sh;
    wclk(4);
    cpol = p; cpha = ph; msbf = m; shrt = s; sclk = p;
    wclk(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      nerr++; nvec++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    wclk(5);
    rst_n = 1;
    wclk(2);
    // R1 reset state
    chk("R1 tx_ready after reset", tx_ready, 1);
    chk("R1 rx_valid after reset", rx_valid, 0);
    chk("R1 R7 miso_oe deselected", miso_oe, 0);

    // R9 before any transfer: repeat word is 0
    frame(8'h5A, 8);
    pop(8'h5A);

    // mode 0, LSB first
    push(8'hA5);
    frame(8'h3C, 8);
    pop(8'h3C);
    // R9 empty buffer repeats A5
    frame(8'hC1, 8);
    pop(8'hC1);

    // mode 1, MSB first
    setcfg(0, 1, 1, 0, 0);
    push(8'h96);
    frame(8'h81, 8);
    pop(8'h81);

    // mode 2 and mode 3
    setcfg(1, 0, 0, 0, 0);
    push(8'h4E);
    frame(8'hB2, 8);
    pop(8'hB2);
    setcfg(1, 1, 1, 0, 0);
    push(8'h1D);
    frame(8'h77, 8);
    pop(8'h77);

    // R5 seven-bit frames, both orders
    setcfg(0, 0, 0, 1, 0);
    push(8'hD3);
    frame(8'hFF, 7);
    pop(8'h7F);
    setcfg(0, 1, 1, 1, 0);
    push(8'hE9);
    frame(8'hAA, 7);
    pop(8'h2A);

    // R7 active-high select
    setcfg(0, 0, 1, 0, 1);
    chk("R7 miso_oe with high select idle", miso_oe, 0);
    push(8'h6B);
    frame(8'h19, 8);
    pop(8'h19);

    // R7 edges ignored while deselected
    setcfg(0, 0, 0, 0, 0);
    push(8'hC7);
    for (int k = 0; k < 16; k++) begin
      mosi = k[0];
      sclk = ~sclk;
      wclk(H);
    end
    chk("R7 no frame while deselected", rx_valid, 0);
    chk("R7 buffer untouched while deselected", tx_ready, 0);
    // R7 unfinished frame dropped
    frame(8'hF0, 3);
    chk("R7 partial frame gives no word", rx_valid, 0);
    chk("R7 partial frame keeps buffer", tx_ready, 0);
    frame(8'h35, 8);
    pop(8'h35);

    // R6 overwrite without consumer
    frame(8'h11, 8);
    chk("R6 valid held", rx_valid, 1);
    frame(8'h22, 8);
    pop(8'h22);

    // R8 three-wire operation
    @(negedge clk);
    four = 0;
    wclk(4);
    chk("R8 miso_oe in three-wire", miso_oe, 1);
    push(8'h8C);
    frame(8'h63, 8);
    pop(8'h63);
    frame(8'h9E, 8);
    pop(8'h9E);

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule